// File: doc/BRIEF.md
# Write-through sixteen-word nibble RAM

This block is a small synchronous single-port memory of sixteen 4-bit words. Each word lives in its own enable-gated storage cell, and every cell is clocked by the single clock that enters the top level. One port carries a read/write select, a write enable, a 4-bit address and a 4-bit data word. A single registered 4-bit output shows the result of the last operation.

Every access completes at one clock edge. A read loads the addressed word into the output register. A write stores the data word into the addressed cell and loads the same word into the output register at that edge, so the output is write-first. When the select asks for a write but the enable is low, the cycle is idle: no cell changes and the output holds.

The ports are plain level signals sampled at each rising edge. The block has no handshake. An access is issued every cycle, and the caller must hold the inputs stable around the edge. A synchronous active-high reset clears only the output register. The stored words survive a reset and are undefined until they are first written.

Top module: `wt_ram16x4`

## Requirements
- R1: While `rst` is 1 at a rising edge, `rdata` becomes 0 after that edge. The stored words are not cleared: a word written before the reset reads back unchanged after it.
- R2: When `rw_sel` is 0 (write) and `wr_en` is 1 at a rising edge, the word at `addr` takes the value of `wdata`.
- R3: On such a write, `rdata` equals the written `wdata` right after the same edge.
- R4: When `rw_sel` is 0 and `wr_en` is 0 at an edge, no word changes and `rdata` keeps its previous value.
- R5: When `rw_sel` is 1 (read) at an edge, `rdata` becomes the word stored at `addr` after that edge. This holds for either value of `wr_en`, and a read never modifies any word.
- R6: A write changes only the addressed word. The other fifteen words keep their values.
- R7: Addressing is zero-based: `addr` value k (0 to 15) selects word k, so 4'b0011 selects the fourth word, and all sixteen addresses map to distinct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, shared by every storage cell and the output register |
| rst | input | 1 | Synchronous active-high reset of the output register only |
| rw_sel | input | 1 | 1 = read, 0 = write |
| wr_en | input | 1 | Write enable; a write takes place only when this is 1 and rw_sel is 0 |
| addr | input | 4 | Word address, zero-based |
| wdata | input | 4 | Data word to store |
| rdata | output | 4 | Registered result: the word read, or the word just written |

## Verification
Any corrupted word becomes visible at `rdata` one edge after the first read of its address. The bench therefore interleaves writes with reads of the written word and of its neighbours, so that a strobe sent to the wrong cell, or a cell that loads without a strobe, shows up within a few cycles. A wrong output-register decision shows on the very next edge. Examples are a read gated by the enable, a write that is not shown, or an idle cycle that reloads the register. For this reason the reference model is compared at every clock, across idle cycles, reads with the enable high and a reset issued in mid-run.

// File: rtl/wt_ram_pkg.sv
package wt_ram_pkg;
  localparam int unsigned DATA_W_DEF = 4;
  localparam int unsigned ADDR_W_DEF = 4;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } access_e;

  function automatic access_e decode_access(input logic rw, input logic en);
    if (rw)      return ACC_READ;
    else if (en) return ACC_WRITE;
    else         return ACC_IDLE;
  endfunction
endpackage

// File: rtl/wt_store_cell.sv
module wt_store_cell #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (load) bits_q <= din;
  end

  assign dout = bits_q;
endmodule

// File: rtl/wt_write_decode.sv
module wt_write_decode #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  strobe
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_line
    assign strobe[k] = go && (addr == ADDR_W'(k));
  end
endmodule

// File: rtl/wt_read_select.sv
module wt_read_select #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] words,
  input  logic [ADDR_W-1:0]           addr,
  output logic [WIDTH-1:0]            word
);
  always_comb begin
    word = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (addr == ADDR_W'(k)) word = words[k];
    end
  end
endmodule

// File: rtl/wt_out_stage.sv
module wt_out_stage
  import wt_ram_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  access_e          acc,
  input  logic [WIDTH-1:0] rd_word,
  input  logic [WIDTH-1:0] wr_word,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (acc)
        ACC_READ:  q <= rd_word;
        ACC_WRITE: q <= wr_word;
        default:   q <= q;
      endcase
    end
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("R1 output not cleared by reset");
  assert_write_first_R3: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WRITE) |=> (q == $past(wr_word)))
    else $error("R3 written word not shown");
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_IDLE) |=> $stable(q))
    else $error("R4 output moved on idle cycle");
endmodule

// File: rtl/wt_ram16x4.sv
module wt_ram16x4
  import wt_ram_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rw_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  access_e                        acc;
  logic [DEPTH-1:0]               strobe;
  logic [DEPTH-1:0][DATA_W-1:0]   cell_q;
  logic [DATA_W-1:0]              sel_word;

  assign acc = decode_access(rw_sel, wr_en);

  wt_write_decode #(.ADDR_W(ADDR_W)) u_dec (
    .go     (acc == ACC_WRITE),
    .addr   (addr),
    .strobe (strobe)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_cell
    wt_store_cell #(.WIDTH(DATA_W)) u_cell (
      .clk  (clk),
      .load (strobe[k]),
      .din  (wdata),
      .dout (cell_q[k])
    );

    assert_cell_load_R2: assert property (@(posedge clk) disable iff (rst)
      strobe[k] |=> (cell_q[k] == $past(wdata)))
      else $error("R2 cell did not capture data");
    assert_cell_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !strobe[k] |=> $stable(cell_q[k]))
      else $error("R6 unselected cell changed");
  end

  wt_read_select #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_sel (
    .words (cell_q),
    .addr  (addr),
    .word  (sel_word)
  );

  wt_out_stage #(.WIDTH(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .rd_word (sel_word),
    .wr_word (wdata),
    .q       (rdata)
  );

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe))
    else $error("R6 more than one write strobe");
  assert_addr_map_R7: assert property (@(posedge clk) disable iff (rst)
    (!rw_sel && wr_en) |-> strobe[addr])
    else $error("R7 strobe not on addressed word");
  assert_read_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
    rw_sel |-> (strobe == '0))
    else $error("R5 read raised a write strobe");
  assert_read_data_R5: assert property (@(posedge clk) disable iff (rst)
    rw_sel |=> (rdata == $past(sel_word)))
    else $error("R5 read word not delivered");
endmodule

// File: tb/tb_wt_ram16x4.sv
module tb_wt_ram16x4;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rw_sel = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;
  int model_mem [16];
  int model_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_ram16x4 dut (
    .clk(clk), .rst(rst), .rw_sel(rw_sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic step(input bit r, input bit rw, input bit en,
                      input int a, input int d, input string tag);
    @(negedge clk);
    rst = r; rw_sel = rw; wr_en = en; addr = 4'(a); wdata = 4'(d);
    @(posedge clk);
    if (r)        model_out = 0;
    else if (rw)  model_out = model_mem[a];
    else if (en) begin model_mem[a] = d; model_out = d; end
    @(negedge clk);
    vectors++;
    if (int'(rdata) != model_out) begin
      misses++;
      $display("FAIL %s: addr=%0d rdata=%0d expected=%0d", tag, a, rdata, model_out);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int lfsr;
    step(1, 1, 0, 0, 0, "R1 reset");
    step(1, 0, 1, 5, 9, "R1 reset blocks output");
    // R2 R3 R7: fill every word with a distinct pattern
    for (int i = 0; i < 16; i++) step(0, 0, 1, i, (i*7+3) & 15, "R2 R3 R7 fill");
    // R5 R7: read back with enable toggling
    for (int i = 0; i < 16; i++) step(0, 1, i % 2, i, 15 - i, "R5 R7 readback");
    // R4: idle cycles keep output and contents
    step(0, 0, 1, 2, 6, "R3 write");
    step(0, 0, 0, 2, 11, "R4 idle hold");
    step(0, 0, 0, 9, 0, "R4 idle hold");
    step(0, 1, 0, 2, 0, "R4 no store");
    // R6: address 3 (fourth word), neighbours untouched
    step(0, 0, 1, 3, 8, "R3 R7 write fourth word");
    step(0, 1, 0, 2, 0, "R6 neighbour");
    step(0, 1, 0, 4, 0, "R6 neighbour");
    step(0, 1, 0, 3, 0, "R2 R7 fourth word");
    // R5: read with enable high must not store
    step(0, 1, 1, 7, 1, "R5 read en high");
    step(0, 1, 0, 7, 0, "R5 unchanged");
    // R1: mid-run reset keeps memory
    step(1, 1, 0, 3, 0, "R1 reset midrun");
    step(0, 1, 0, 3, 0, "R1 memory kept");
    // mixed traffic
    lfsr = 32'h1ACE;
    for (int n = 0; n < 400; n++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step(0, lfsr[0], lfsr[1], (lfsr >> 2) & 15, (lfsr >> 6) & 15, "R2 R4 R5 R6 mixed");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule